// File: doc/BRIEF.md
# Byte-Buffered I2C Bus Master

This block is an I2C bus master that runs write and read transfers on SCL and an open-drain SDA. Software sees three byte-wide registers: control, status and data. The data register is separate from the shift register. While one byte is still going out on the bus, software can already place the next byte in the data register. The controller asks for that next byte early: the transmit-empty flag and the interrupt come up as soon as the first bit of the byte just loaded has left the shift register. The controller also generates START and STOP, samples the slave's acknowledge, and receives bytes during read transfers.

The direction of a transfer is taken from bit 0 of the first byte sent after START. For 10-bit addressing, software writes the second address byte as the next byte in the transfer, in response to the interrupt raised during the first one. Lines are modelled as open drain: each `*_oe` output high pulls its line low, and `sda_in` returns the real SDA level. The bus runs in quarter-bit phases of `QDIV` clock cycles each.

Register offsets are 0 (control), 1 (status) and 2 (data).
- Control bits: bit 0 requests START, bit 1 requests STOP, bit 2 clears the NACK flag.
- Status bits: bit 0 ACK, bit 1 TXE (data register empty), bit 2 RXF (received byte waiting), bit 3 NACK, bit 4 BUSY.

The state machine has these states:
- IDLE: both lines released.
- START: SDA is pulled low while SCL stays released.
- BIT: eight clocked data bits.
- ACK: the ninth clock.
- HOLD: SCL is held low between bytes until there is a next action.
- STOP: SDA is released while SCL is high.

The transitions are:
- IDLE→START when a start request is pending.
- START→BIT, which loads the data register into the shift register.
- BIT→ACK after the eighth bit.
- ACK→STOP on a slave NACK, or on a master NACK during a read.
- ACK→HOLD otherwise.
- HOLD→BIT during a read, or during a write once new data is present.
- HOLD→STOP during a write once a stop has been requested.
- STOP→IDLE.

Top module: `i2cm_master`

## Requirements
- R1: After reset, status reads 0x02 (only TXE set), SCL and SDA are both released, and irq is low.
- R2: A transfer opens with exactly one START (SDA falling while SCL is released) and closes with exactly one STOP (SDA rising while SCL is released); at all other times SDA changes only while SCL is low.
- R3: Writing control bit 0 in IDLE sends the data-register byte, then each later byte. Bits go out most significant first, with one SCL pulse per bit and a ninth pulse for the acknowledge.
- R4: Writing the data register (offset 2) clears TXE (status bit 1). TXE sets again once the first bit of the byte just loaded has been shifted out. irq is high while TXE is set during a write transfer.
- R5: When a write byte and its acknowledge are done and the data register is still empty, SCL is held low until software writes a byte. That byte is then sent.
- R6: Status bit 0 (ACK) shows whether the slave pulled SDA low during the ninth clock of the last byte written.
- R7: A missing acknowledge sets NACK (status bit 3) and irq, stops further bytes, and produces STOP. Control bit 2, or a new START, clears NACK.
- R8: Writing control bit 1 while a byte is in flight lets that byte and its acknowledge clock finish, then produces STOP.
- R9: A 10-bit address goes out as a first byte 11110xx0 followed by the low address byte, written by software on the interrupt raised during the first byte.
- R10: If bit 0 of the first byte is 1 and the slave acknowledges it, the controller releases SDA and receives bytes. Each byte moves to the data register and sets RXF (status bit 2) and irq. Reading the data register clears RXF.
- R11: During a read, the controller drives ACK (SDA low) after each byte. It releases SDA (NACK) on the byte during which a stop was requested, then produces STOP.
- R12: BUSY (status bit 4) is set from the start request until the STOP has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (reading data clears RXF) |
| reg_addr | input | 2 | Register offset: 0 control, 1 status, 2 data |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for the addressed register |
| irq | output | 1 | Interrupt: TXE during a write, RXF, or NACK |
| scl_oe | output | 1 | High pulls SCL low |
| sda_oe | output | 1 | High pulls SDA low |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
A wrong phase or state shows up on the lines within one quarter-bit. It appears as an extra START or STOP edge, a missing ninth clock, or bits shifted by one position in the byte the slave collects. A wrong buffer flag shows up at the next status poll: TXE rising a whole byte late or early, RXF failing to clear on a data read, or NACK missing after a refused byte. A wrong direction or acknowledge decision in a read shows up one byte later. It appears as a driven ACK where a NACK belongs, or as the slave still driving data when STOP should begin.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT,
        ST_ACK,
        ST_HOLD,
        ST_STOP
    } i2cm_state_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;

    localparam int CB_GO   = 0;
    localparam int CB_HALT = 1;
    localparam int CB_CLRN = 2;

    localparam int SB_ACK  = 0;
    localparam int SB_TXE  = 1;
    localparam int SB_RXF  = 2;
    localparam int SB_NACK = 3;
    localparam int SB_BUSY = 4;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/i2cm_shreg.sv
module i2cm_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift)
            q <= {q[W-2:0], sin};
    end
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
    import i2cm_pkg::*;
#(
    parameter int DW   = 8,
    parameter int QDIV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq,
    output logic          scl_oe,
    output logic          sda_oe,
    input  logic          sda_in
);
    localparam int BCW = $clog2(DW);
    localparam logic [BCW-1:0] TOP_BIT = BCW'(DW - 1);

    i2cm_state_e state, nstate;
    logic [1:0]    ph;
    logic [BCW-1:0] bitcnt;
    logic [DW-1:0] data_q, sh_q;
    logic txe, rxf, ack_q, nack_q, start_req, stop_req;
    logic rd_mode, rd_dir, addr_byte, give_nack, samp, ack_got;
    logic tick, q_end, sh_load, sh_shift, first_out, ack_end, stop_done;
    logic wr_ctrl, wr_data, rd_data, busy, scl_d, sda_d;

    i2cm_tick #(.QDIV(QDIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    i2cm_shreg #(.W(DW)) u_sh (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .din(data_q),
        .shift(sh_shift), .sin(samp), .q(sh_q)
    );

    assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
    assign wr_data   = reg_wr && (reg_addr == RA_DATA);
    assign rd_data   = reg_rd && (reg_addr == RA_DATA);
    assign busy      = (state != ST_IDLE) || start_req;
    assign q_end     = tick && (ph == 2'd3);
    assign sh_shift  = q_end && (state == ST_BIT);
    assign first_out = sh_shift && (bitcnt == TOP_BIT) && !rd_mode;
    assign ack_end   = q_end && (state == ST_ACK);
    assign stop_done = q_end && (state == ST_STOP);
    assign sh_load   = (q_end && state == ST_START) ||
                       (tick && state == ST_HOLD && !rd_mode && !stop_req && !txe);

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:  if (tick && start_req) nstate = ST_START;
            ST_START: if (q_end) nstate = ST_BIT;
            ST_BIT:   if (q_end && bitcnt == '0) nstate = ST_ACK;
            ST_ACK:   if (q_end) begin
                          if (!rd_mode && !ack_got)     nstate = ST_STOP;
                          else if (rd_mode && give_nack) nstate = ST_STOP;
                          else                           nstate = ST_HOLD;
                      end
            ST_HOLD:  if (tick) begin
                          if (rd_mode)       nstate = ST_BIT;
                          else if (stop_req) nstate = ST_STOP;
                          else if (!txe)     nstate = ST_BIT;
                      end
            ST_STOP:  if (q_end) nstate = ST_IDLE;
        endcase
    end

    // state register and quarter-bit phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ph    <= 2'd0;
        end else begin
            state <= nstate;
            if (nstate != state)
                ph <= 2'd0;
            else if (tick && state != ST_IDLE && state != ST_HOLD)
                ph <= ph + 2'd1;
        end
    end

    // buffers, flags and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;  txe <= 1'b1;  rxf <= 1'b0;  ack_q <= 1'b0;
            nack_q <= 1'b0;  start_req <= 1'b0;  stop_req <= 1'b0;
            rd_mode <= 1'b0;  rd_dir <= 1'b0;  addr_byte <= 1'b0;
            give_nack <= 1'b0;  samp <= 1'b0;  ack_got <= 1'b0;
            bitcnt <= '0;
        end else begin
            if (wr_ctrl && reg_wdata[CB_GO] && state == ST_IDLE && !start_req) begin
                start_req <= 1'b1;
                nack_q    <= 1'b0;
            end
            if (state == ST_IDLE && nstate == ST_START) start_req <= 1'b0;
            if (wr_ctrl && reg_wdata[CB_CLRN]) nack_q <= 1'b0;
            if (wr_ctrl && reg_wdata[CB_HALT] && busy) stop_req <= 1'b1;
            if (stop_done) begin
                stop_req <= 1'b0;
                rd_mode  <= 1'b0;
            end
            if (wr_data) begin
                data_q <= reg_wdata;
                txe    <= 1'b0;
            end
            if (first_out) txe <= 1'b1;
            if (rd_data) rxf <= 1'b0;
            if (q_end && state == ST_START) begin
                addr_byte <= 1'b1;
                rd_dir    <= data_q[0];
            end
            if (tick && ph == 2'd2 && state == ST_BIT) samp <= sda_in;
            if (tick && ph == 2'd2 && state == ST_ACK) ack_got <= !sda_in;
            if (state == ST_BIT && nstate == ST_ACK) give_nack <= stop_req;
            if (ack_end) begin
                addr_byte <= 1'b0;
                if (rd_mode) begin
                    data_q <= sh_q;
                    rxf    <= 1'b1;
                end else begin
                    ack_q <= ack_got;
                    if (!ack_got)
                        nack_q <= 1'b1;
                    else if (addr_byte && rd_dir)
                        rd_mode <= 1'b1;
                end
            end
            if (nstate == ST_BIT && state != ST_BIT)
                bitcnt <= TOP_BIT;
            else if (sh_shift && bitcnt != '0)
                bitcnt <= bitcnt - 1'b1;
        end
    end

    // line levels decoded per state and phase
    always_comb begin
        scl_d = 1'b0;
        sda_d = 1'b0;
        unique case (state)
            ST_IDLE:  begin scl_d = 1'b0; sda_d = 1'b0; end
            ST_START: begin scl_d = 1'b0; sda_d = ph[1]; end
            ST_BIT:   begin
                          scl_d = !ph[1];
                          sda_d = (ph == 2'd0) ? sda_oe : (!rd_mode && !sh_q[DW-1]);
                      end
            ST_ACK:   begin
                          scl_d = !ph[1];
                          sda_d = (ph == 2'd0) ? sda_oe : (rd_mode && !give_nack);
                      end
            ST_HOLD:  begin scl_d = 1'b1; sda_d = sda_oe; end
            ST_STOP:  begin
                          scl_d = !ph[1];
                          sda_d = (ph == 2'd0) ? sda_oe : (ph != 2'd3);
                      end
        endcase
    end

    // registered line outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            scl_oe <= scl_d;
            sda_oe <= sda_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_GO]   = start_req;
                reg_rdata[CB_HALT] = stop_req;
            end
            RA_STAT: begin
                reg_rdata[SB_ACK]  = ack_q;
                reg_rdata[SB_TXE]  = txe;
                reg_rdata[SB_RXF]  = rxf;
                reg_rdata[SB_NACK] = nack_q;
                reg_rdata[SB_BUSY] = busy;
            end
            RA_DATA: reg_rdata = data_q;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (txe && !rd_mode && state != ST_IDLE) || rxf || nack_q;
endmodule

// File: rtl/i2cm_master_chk.sv
module i2cm_master_chk
    import i2cm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input i2cm_state_e state,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        txe,
    input logic        rxf,
    input logic        nack_q,
    input logic        rd_mode
);
    // R2: SDA pulled low with SCL released only in the START state
    p_start_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> ($past(state) == ST_START));

    // R2: SDA released with SCL released only in the STOP state
    p_stop_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> ($past(state) == ST_STOP));

    // R1: settled idle leaves both lines released
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!scl_oe && !sda_oe));

    // R4: TXE only rises while a byte is shifting
    p_txe_in_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txe) |-> ($past(state) == ST_BIT));

    // R10: RXF only rises at the end of a receive acknowledge
    p_rxf_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxf) |-> ($past(state) == ST_ACK && $past(rd_mode)));

    // R7: a refused byte sends the controller to STOP
    p_nack_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_q) |-> (state == ST_STOP));
endmodule

bind i2cm_master i2cm_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .txe(txe), .rxf(rxf), .nack_q(nack_q), .rd_mode(rd_mode)
);

// File: tb/sim_i2cm_master.sv
`timescale 1ns/1ps
module sim_i2cm_master;
    import i2cm_pkg::*;
    localparam int QDIV = 4;
    // {first byte, second byte, third byte, index of byte the slave refuses (3 = none)}
    localparam logic [31:0] VEC [5] = '{
        {8'h90, 8'h11, 8'hC3, 8'd3},
        {8'hA4, 8'h00, 8'hFF, 8'd3},
        {8'hF4, 8'h5A, 8'h81, 8'd3},
        {8'h3E, 8'h77, 8'h66, 8'd1},
        {8'h50, 8'h12, 8'h34, 8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic reg_wr = 0, reg_rd = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic s_oe = 1'b0;
    wire scl_line = ~scl_oe;
    wire sda_line = ~(sda_oe | s_oe);

    i2cm_master #(.DW(8), .QDIV(QDIV)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
    );

    int checks = 0, errors = 0;
    int n_start, n_stop, s_cnt, s_idx, r_idx, nack_pos;
    logic [7:0] s_byte, rd_byte;
    logic [7:0] s_log [0:7];
    logic m_ack [0:3];
    logic s_rd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // slave model
    always @(negedge sda_line) if (scl_line === 1'b1) begin
        n_start++; s_cnt = 0; s_idx = 0; r_idx = 0; s_rd = 0; s_oe = 0;
    end
    always @(posedge sda_line) if (scl_line === 1'b1) n_stop++;
    always @(posedge scl_line) begin
        if (s_cnt < 8) begin
            s_byte = {s_byte[6:0], sda_line};
            s_cnt++;
        end else begin
            s_cnt = 0;
            if (s_rd) begin
                m_ack[r_idx] = !sda_line;
                if (sda_line) s_rd = 0;
                r_idx++;
                rd_byte = 8'h3C;
            end else if (s_idx == 1 && s_log[0][0] && s_oe) begin
                s_rd = 1;
                rd_byte = 8'hA5;
            end
        end
    end
    always @(negedge scl_line) begin
        if (s_cnt == 8) begin
            if (!s_rd) begin
                if (s_idx < 8) s_log[s_idx] = s_byte;
                s_oe = (s_idx != nack_pos);
                s_idx++;
            end else s_oe = 1'b0;
        end else s_oe = s_rd ? !rd_byte[7 - s_cnt] : 1'b0;
    end

    task automatic clr_slave(input int np);
        n_start = 0; n_stop = 0; s_cnt = 0; s_idx = 0; r_idx = 0;
        s_rd = 0; nack_pos = np;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic wait_txe(output bit ab);
        logic [7:0] s;
        ab = 0;
        for (int i = 0; i < 3000; i++) begin
            rd(RA_STAT, s);
            if (s[SB_NACK]) begin ab = 1; return; end
            if (s[SB_TXE] && s[SB_BUSY]) begin
                chk("R4 irq while TXE", irq, 1);
                return;
            end
        end
        ab = 1;
        chk("R4 TXE timeout", 0, 1);
    endtask

    task automatic wait_stat(input int bitn, input logic val);
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd(RA_STAT, s);
            if (s[bitn] == val) return;
        end
        chk("R12 status poll timeout", 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] st, dv;
        logic [7:0] b [3];
        bit ab;
        int np, cnt;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        clr_slave(9);

        // R1 reset state
        rd(RA_STAT, st);
        chk("R1 status after reset", st, 8'h02);
        chk("R1 lines released", {scl_oe, sda_oe}, 2'b00);
        chk("R1 irq low", irq, 0);

        // vector table of write transfers
        for (int v = 0; v < 5; v++) begin
            b[0] = VEC[v][31:24]; b[1] = VEC[v][23:16]; b[2] = VEC[v][15:8];
            np = int'(VEC[v][7:0]);
            clr_slave(np);
            wr(RA_DATA, b[0]);
            wr(RA_CTRL, 8'h01);
            rd(RA_STAT, st);
            chk("R12 busy after start", st[SB_BUSY], 1);
            ab = 0;
            for (int k = 1; k < 3; k++) begin
                wait_txe(ab);
                if (ab) break;
                wr(RA_DATA, b[k]);
            end
            if (!ab) begin
                wait_txe(ab);
                if (!ab) wr(RA_CTRL, 8'h02);
            end
            wait_stat(SB_BUSY, 0);
            cnt = (np < 3) ? np + 1 : 3;
            chk("R3 R7 byte count at slave", s_idx, cnt);
            for (int k = 0; k < 3; k++)
                if (k < cnt) chk("R3 R9 R8 byte value", s_log[k], b[k]);
            rd(RA_STAT, st);
            chk("R6 ack status", st[SB_ACK], (np < 3) ? 0 : 1);
            chk("R7 nack status", st[SB_NACK], (np < 3) ? 1 : 0);
            chk("R7 irq after transfer", irq, (np < 3) ? 1 : 0);
            chk("R2 R8 one start one stop", {n_start[7:0], n_stop[7:0]}, 16'h0101);
            if (np < 3) begin
                wr(RA_CTRL, 8'h04);
                rd(RA_STAT, st);
                chk("R7 nack cleared by control bit 2", st[SB_NACK], 0);
            end
        end

        // R5 hold SCL low until the next byte arrives
        clr_slave(9);
        wr(RA_DATA, 8'h42);
        wr(RA_CTRL, 8'h01);
        wait_txe(ab);
        repeat (300) @(negedge clk);
        chk("R5 SCL held low while empty", scl_oe, 1);
        chk("R5 only address sent", s_idx, 1);
        wr(RA_DATA, 8'h99);
        wait_txe(ab);
        wr(RA_CTRL, 8'h02);
        wait_stat(SB_BUSY, 0);
        chk("R5 late byte sent", s_log[1], 8'h99);
        chk("R5 byte count", s_idx, 2);

        // R10 R11 read transfer
        clr_slave(9);
        wr(RA_DATA, 8'h91);
        wr(RA_CTRL, 8'h01);
        wait_stat(SB_RXF, 1);
        chk("R10 irq on RXF", irq, 1);
        rd(RA_DATA, dv);
        chk("R10 first received byte", dv, 8'hA5);
        rd(RA_STAT, st);
        chk("R10 RXF cleared by data read", st[SB_RXF], 0);
        wr(RA_CTRL, 8'h02);
        wait_stat(SB_RXF, 1);
        rd(RA_DATA, dv);
        chk("R10 second received byte", dv, 8'h3C);
        wait_stat(SB_BUSY, 0);
        chk("R11 master ACK on first byte", m_ack[0], 1);
        chk("R11 master NACK on last byte", m_ack[1], 0);
        chk("R2 R11 read start and stop", {n_start[7:0], n_stop[7:0]}, 16'h0101);
        chk("R1 lines released after stop", {scl_oe, sda_oe}, 2'b00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule